// File: doc/BRIEF.md
# Per-Block Read Disturb Tracker

This block keeps a running count of page reads for every erase block of a NAND array. Reads are counted per block, not per page, because the block is the smallest unit that can be erased. When a block's count reaches the limit for the attached cell type, the block issues a one-cycle relocate request carrying the block address. The surrounding controller then copies the data elsewhere and erases the old block. An erase of a block returns its count to zero and re-arms its request.

Several read ports can report page reads in the same cycle. Reads to the same block in one cycle are merged into a single update. Crossings that land in the same cycle are serialised through a small pending queue, so the request output carries at most one address per cycle. The count of any block can be read back at any time through a combinational lookup port.

Top module: `rdt_tracker`

## Requirements
- R1: Each accepted read on any port adds one to the count of its block. N ports reading the same block in one cycle add N. `peek_count` shows the count of block `peek_block` in the same cycle, and reflects every update made at earlier clock edges.
- R2: With `cell_mlc` = 0 (single-level cells), the limit is SLC_LIMIT (default 1,000,000 reads).
- R3: With `cell_mlc` = 1 (multi-level cells), the limit is MLC_LIMIT (default 100,000 reads).
- R4: A count never goes above the active limit. A read that would step past the limit stores the limit. A count already at or above the active limit is not changed by reads.
- R5: The read that brings a block's count up to the limit produces exactly one relocate request. The request is `reloc_valid` high for one cycle with `reloc_block` set to that block. If the queue is empty, it appears in the cycle after the clock edge that takes the read.
- R6: A block at its limit raises no further request on later reads until it has been erased.
- R7: An erase sets the erased block's count to zero. Counting and the relocate request are then armed again.
- R8: When a read and an erase name the same block in the same cycle, the erase wins: the count ends at zero and no request is raised. Reads to other blocks in that cycle are counted normally.
- R9: Several crossings in one cycle are emitted on consecutive cycles, lower port number first, and behind any requests already pending. Up to QDEPTH (default 4) requests wait in the queue, oldest first.
- R10: After reset, every count is zero and no request is raised. The reset input is asserted asynchronously and released on a clock edge after two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_mlc | input | 1 | Cell type: 0 single-level, 1 multi-level |
| rd_valid | input | RD_PORTS | Page-read event, one bit per port |
| rd_block | input | RD_PORTS*BLK_W | Block address per port; port p occupies bits p*BLK_W upward |
| er_valid | input | 1 | Block-erase event |
| er_block | input | BLK_W | Block being erased |
| peek_block | input | BLK_W | Block whose count is read back |
| peek_count | output | CNT_W | Current count of `peek_block` |
| reloc_valid | output | 1 | One-cycle relocate request strobe |
| reloc_block | output | BLK_W | Block to relocate, valid with `reloc_valid` |

## Verification
The bench builds the block with 16 blocks, two read ports, a queue depth of 4 and limits of 40 (single-level) and 12 (multi-level). With these limits every threshold is reached in a few dozen reads. A dual-port read steps a count of 39 over 40, which exercises the clamp. Three back-to-back cycles of two simultaneous crossings push the pending queue to three occupied slots, so the emission order can be compared against a scoreboard. The switch to multi-level mode is made after single-level blocks have saturated, which shows that those blocks stay held and silent while fresh blocks, erases and same-cycle read/erase collisions follow the lower limit.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  typedef enum logic {
    CELL_SLC = 1'b0,
    CELL_MLC = 1'b1
  } cell_kind_e;
endpackage

// File: rtl/rdt_reset_sync.sv
module rdt_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/rdt_count_bank.sv
module rdt_count_bank
  import rdt_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS = 2048,
  parameter int unsigned RD_PORTS   = 2,
  parameter int unsigned SLC_LIMIT  = 1000000,
  parameter int unsigned MLC_LIMIT  = 100000,
  parameter int unsigned BLK_W      = 11,
  parameter int unsigned CNT_W      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cell_kind_e        cell_kind,
  input  logic [RD_PORTS-1:0] rd_valid,
  input  logic [BLK_W-1:0]  rd_block [RD_PORTS],
  input  logic              er_valid,
  input  logic [BLK_W-1:0]  er_block,
  input  logic [BLK_W-1:0]  peek_block,
  output logic [CNT_W-1:0]  peek_count,
  output logic [RD_PORTS-1:0] cross_valid,
  output logic [BLK_W-1:0]  cross_block [RD_PORTS]
);
  localparam int unsigned IW = $clog2(RD_PORTS + 1);
  localparam logic [CNT_W-1:0] SLC_L = CNT_W'(SLC_LIMIT);
  localparam logic [CNT_W-1:0] MLC_L = CNT_W'(MLC_LIMIT);

  logic [CNT_W-1:0] cnt_q [NUM_BLOCKS];
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] old_c [RD_PORTS];
  logic [CNT_W-1:0] new_c [RD_PORTS];
  logic [CNT_W:0]   sum_c [RD_PORTS];
  logic [IW-1:0]    inc_c [RD_PORTS];
  logic [RD_PORTS-1:0] lead;
  logic [RD_PORTS-1:0] upd;

  // next-state: merge same-block reads onto the lowest port, erase has priority
  always_comb begin
    lim = (cell_kind == CELL_MLC) ? MLC_L : SLC_L;
    for (int p = 0; p < RD_PORTS; p++) begin
      lead[p]  = rd_valid[p] && !(er_valid && (er_block == rd_block[p]));
      inc_c[p] = '0;
      for (int q = 0; q < RD_PORTS; q++) begin
        if (rd_valid[q] && (rd_block[q] == rd_block[p])) begin
          inc_c[p] = inc_c[p] + IW'(1);
          if (q < p) lead[p] = 1'b0;
        end
      end
      old_c[p] = cnt_q[rd_block[p]];
      sum_c[p] = {1'b0, old_c[p]} + (CNT_W+1)'(inc_c[p]);
      new_c[p] = (sum_c[p] >= {1'b0, lim}) ? lim : sum_c[p][CNT_W-1:0];
      upd[p]   = lead[p] && (old_c[p] < lim);
      cross_valid[p] = upd[p] && (new_c[p] == lim);
      cross_block[p] = rd_block[p];
    end
  end

  // register: per-port write enables, erase written last so it wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BLOCKS; i++) cnt_q[i] <= '0;
    end else begin
      for (int p = 0; p < RD_PORTS; p++) begin
        if (upd[p]) cnt_q[rd_block[p]] <= new_c[p];
      end
      if (er_valid) cnt_q[er_block] <= '0;
    end
  end

  assign peek_count = cnt_q[peek_block];

  assert_erase_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    er_valid |=> (cnt_q[$past(er_block)] == '0));

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_sat_chk
    assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid[p] && (cnt_q[rd_block[p]] < lim)) |=> (cnt_q[$past(rd_block[p])] <= $past(lim)));
  end
endmodule

// File: rtl/rdt_relocate_queue.sv
module rdt_relocate_queue #(
  parameter int unsigned RD_PORTS = 2,
  parameter int unsigned QDEPTH   = 4,
  parameter int unsigned BLK_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RD_PORTS-1:0] in_valid,
  input  logic [BLK_W-1:0]  in_block [RD_PORTS],
  output logic              out_valid,
  output logic [BLK_W-1:0]  out_block
);
  localparam int unsigned LW = QDEPTH + RD_PORTS;
  localparam int unsigned TW = $clog2(LW + 1);
  localparam int unsigned FW = $clog2(QDEPTH + 1);

  logic [BLK_W-1:0] q_blk   [QDEPTH];
  logic [BLK_W-1:0] q_blk_d [QDEPTH];
  logic [BLK_W-1:0] lst     [LW];
  logic [FW-1:0]    fill_q, fill_d;
  logic [TW-1:0]    total;
  logic             out_valid_d;
  logic [BLK_W-1:0] out_block_d;
  logic             shift_en;

  // next-state: pending entries first, then new crossings in port order
  always_comb begin
    for (int i = 0; i < QDEPTH; i++) lst[i] = q_blk[i];
    for (int i = QDEPTH; i < LW; i++) lst[i] = '0;
    total = TW'(fill_q);
    for (int p = 0; p < RD_PORTS; p++) begin
      if (in_valid[p]) begin
        lst[total] = in_block[p];
        total      = total + TW'(1);
      end
    end
    out_valid_d = (total != '0);
    out_block_d = lst[0];
    for (int i = 0; i < QDEPTH; i++) q_blk_d[i] = lst[i+1];
    if (total == '0)                  fill_d = '0;
    else if (total > TW'(QDEPTH + 1)) fill_d = FW'(QDEPTH);
    else                              fill_d = FW'(total - TW'(1));
    shift_en = out_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q    <= '0;
      out_valid <= 1'b0;
      out_block <= '0;
      for (int i = 0; i < QDEPTH; i++) q_blk[i] <= '0;
    end else begin
      fill_q    <= fill_d;
      out_valid <= out_valid_d;
      if (shift_en) begin
        out_block <= out_block_d;
        for (int i = 0; i < QDEPTH; i++) q_blk[i] <= q_blk_d[i];
      end
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    total <= TW'(QDEPTH + 1));

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q != '0) |=> out_valid);
endmodule

// File: rtl/rdt_tracker.sv
module rdt_tracker
  import rdt_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS = 2048,
  parameter int unsigned RD_PORTS   = 2,
  parameter int unsigned SLC_LIMIT  = 1000000,
  parameter int unsigned MLC_LIMIT  = 100000,
  parameter int unsigned QDEPTH     = 4,
  localparam int unsigned BLK_W     = $clog2(NUM_BLOCKS),
  localparam int unsigned CNT_W     = $clog2(((SLC_LIMIT > MLC_LIMIT) ? SLC_LIMIT : MLC_LIMIT) + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cell_mlc,
  input  logic [RD_PORTS-1:0]       rd_valid,
  input  logic [RD_PORTS*BLK_W-1:0] rd_block,
  input  logic                      er_valid,
  input  logic [BLK_W-1:0]          er_block,
  input  logic [BLK_W-1:0]          peek_block,
  output logic [CNT_W-1:0]          peek_count,
  output logic                      reloc_valid,
  output logic [BLK_W-1:0]          reloc_block
);
  logic             rst_sync_n;
  logic [BLK_W-1:0] rd_blk_a  [RD_PORTS];
  logic [BLK_W-1:0] cross_blk [RD_PORTS];
  logic [RD_PORTS-1:0] cross_v;
  cell_kind_e       kind;

  assign kind = cell_kind_e'(cell_mlc);

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_unpack
    assign rd_blk_a[p] = rd_block[p*BLK_W +: BLK_W];
  end

  rdt_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rdt_count_bank #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .RD_PORTS   (RD_PORTS),
    .SLC_LIMIT  (SLC_LIMIT),
    .MLC_LIMIT  (MLC_LIMIT),
    .BLK_W      (BLK_W),
    .CNT_W      (CNT_W)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cell_kind   (kind),
    .rd_valid    (rd_valid),
    .rd_block    (rd_blk_a),
    .er_valid    (er_valid),
    .er_block    (er_block),
    .peek_block  (peek_block),
    .peek_count  (peek_count),
    .cross_valid (cross_v),
    .cross_block (cross_blk)
  );

  rdt_relocate_queue #(
    .RD_PORTS (RD_PORTS),
    .QDEPTH   (QDEPTH),
    .BLK_W    (BLK_W)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (cross_v),
    .in_block  (cross_blk),
    .out_valid (reloc_valid),
    .out_block (reloc_block)
  );
endmodule

// File: tb/sim_rdt_tracker.sv
module sim_rdt_tracker;
  localparam int NB = 16;
  localparam int LIM_S = 40;
  localparam int LIM_M = 12;

  logic       clk;
  logic       rst_n;
  logic       cell_mlc;
  logic [1:0] rd_valid;
  logic [7:0] rd_block;
  logic       er_valid;
  logic [3:0] er_block;
  logic [3:0] peek_block;
  logic [5:0] peek_count;
  logic       reloc_valid;
  logic [3:0] reloc_block;

  int  nchk = 0;
  int  nbad = 0;
  bit  mode = 0;
  bit  mon_en = 0;
  bit  finished = 0;
  int  model [NB];
  int  expq [$];

  rdt_tracker #(.NUM_BLOCKS(NB), .RD_PORTS(2), .SLC_LIMIT(LIM_S), .MLC_LIMIT(LIM_M), .QDEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cell_mlc(cell_mlc), .rd_valid(rd_valid), .rd_block(rd_block),
    .er_valid(er_valid), .er_block(er_block), .peek_block(peek_block), .peek_count(peek_count),
    .reloc_valid(reloc_valid), .reloc_block(reloc_block));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
  endtask

  // driver: apply one cycle of stimulus and push the expected requests
  task automatic step(input bit v0, input int b0, input bit v1, input int b1, input bit ev, input int eb);
    bit vv [2];
    int bb [2];
    int lim, inc, nv;
    @(negedge clk);
    rd_valid = {v1, v0};
    rd_block = {4'(b1), 4'(b0)};
    er_valid = ev;
    er_block = 4'(eb);
    cell_mlc = mode;
    vv[0] = v0; vv[1] = v1; bb[0] = b0; bb[1] = b1;
    lim = mode ? LIM_M : LIM_S;
    for (int p = 0; p < 2; p++) begin
      if (!vv[p]) continue;
      if (ev && eb == bb[p]) continue;
      if (p == 1 && v0 && b0 == b1) continue;
      inc = (p == 0 && v1 && b1 == b0) ? 2 : 1;
      if (model[bb[p]] < lim) begin
        nv = model[bb[p]] + inc;
        if (nv > lim) nv = lim;
        if (nv == lim) expq.push_back(bb[p]);
        model[bb[p]] = nv;
      end
    end
    if (ev) model[eb] = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic peek(input int blk, input string req);
    step(0, 0, 0, 0, 0, 0);
    peek_block = 4'(blk);
    #1;
    check(int'(peek_count) == model[blk], req, int'(peek_count), model[blk]);
  endtask

  task automatic reads(input int blk, input int n);
    for (int i = 0; i < n; i++) step(1, blk, 0, 0, 0, 0);
  endtask

  task automatic dual(input int blk, input int n);
    for (int i = 0; i < n; i++) step(1, blk, 1, blk, 0, 0);
  endtask

  // monitor: compare every strobe against the scoreboard queue
  always @(posedge clk) begin
    #2;
    if (mon_en && reloc_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R5 R6 unexpected relocate", int'(reloc_block), -1);
      end else begin
        int e;
        e = expq.pop_front();
        check(int'(reloc_block) == e, "R5 R9 relocate block", int'(reloc_block), e);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      nchk++; nbad++;
      $display("FAIL R10 watchdog expired: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) model[i] = 0;
    rst_n = 1'b0; cell_mlc = 1'b0; rd_valid = '0; rd_block = '0;
    er_valid = 1'b0; er_block = '0; peek_block = '0;
    #22 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1;
    // R10 reset state
    peek(0, "R10 count after reset");
    peek(15, "R10 count after reset");
    check(reloc_valid == 1'b0, "R10 no strobe after reset", int'(reloc_valid), 0);
    // R1 single-port counting on each port
    reads(3, 5);
    peek(3, "R1 single reads");
    step(0, 0, 1, 3, 0, 0);
    peek(3, "R1 port 1 read");
    // R2 R4 single-level limit, clamp over the limit
    dual(9, 19);
    reads(9, 1);
    peek(9, "R1 merged dual reads");
    dual(9, 1);
    peek(9, "R2 R4 clamp at single-level limit");
    reads(9, 3);
    peek(9, "R4 R6 held at limit");
    // R9 simultaneous crossings through the queue
    for (int b = 10; b < 16; b++) begin
      dual(b, 19);
      reads(b, 1);
    end
    step(1, 10, 1, 11, 0, 0);
    step(1, 12, 1, 13, 0, 0);
    step(1, 14, 1, 15, 0, 0);
    idle(6);
    check(expq.size() == 0, "R9 queue drained", expq.size(), 0);
    peek(10, "R9 count after crossing");
    peek(15, "R9 count after crossing");
    // R3 multi-level mode
    mode = 1;
    peek(9, "R4 saturated block held after mode change");
    peek(3, "R3 count kept across mode change");
    reads(3, 5);
    peek(3, "R3 below multi-level limit");
    step(1, 3, 0, 0, 1, 3);
    peek(3, "R8 erase wins over read");
    reads(3, 12);
    peek(3, "R3 multi-level limit reached");
    reads(3, 2);
    peek(3, "R6 no further count");
    step(0, 0, 0, 0, 1, 3);
    peek(3, "R7 erase clears count");
    reads(3, 12);
    peek(3, "R7 request re-armed");
    step(1, 1, 0, 0, 1, 2);
    peek(1, "R8 other block read counted");
    reads(0, 10);
    dual(0, 1);
    peek(0, "R3 merged crossing at multi-level limit");
    idle(4);
    check(expq.size() == 0, "R5 all requests seen", expq.size(), 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule